// File: doc/BRIEF.md
# Parity-Group Majority Bit Extractor

This block recovers two control bits that a transmitter hides in the parity of the closing samples of each 64-sample audio frame. An upstream stage checks the parity of each sample. For every sample it presents the sample's position in the frame, numbered 1 to 64, and a flag that is 1 when the parity check failed. The extractor uses only the final ten positions and splits them into two groups of five. Within each group it counts the failed checks. When the frame ends it decides each bit by majority vote.

A group in which every check passes gives a 0. A group in which most checks fail gives a 1. Majority voting means one or two corrupted samples per group do not change the recovered bit. A one-cycle valid strobe marks each new pair of bits. Between strobes the bits keep their last value, so a downstream consumer can either act on the strobe or read the bits at any time.

Top module: `ci_parity_vote`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ci_valid` is 0 and `ci_bits` is 2'b00.
- R2: `ci_bits[0]` (the first control bit) is decided from the parity-fail flags of positions 55 to 59 and nothing else.
- R3: `ci_bits[1]` (the second control bit) is decided from the parity-fail flags of positions 60 to 64 and nothing else.
- R4: A group in which all five parity checks pass gives a bit value of 0.
- R5: A bit is 1 when 3 or more of its 5 flags show a failed check, and 0 when 2 or fewer do.
- R6: Samples at positions 1 to 54 never affect either bit, whatever their parity flag.
- R7: `ci_valid` is high for exactly one cycle. That cycle is the one after a sample with index 64 is accepted, and both bits take their new values in that same cycle.
- R8: `ci_bits` keeps its value in every cycle in which `ci_valid` is low.
- R9: Accepting a sample with index 1 clears both group counts, so the results of an unfinished frame are discarded.
- R10: In a cycle where `smp_valid` is low, the index and flag inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample result is presented this cycle |
| smp_index | input | 7 | Position of the sample in its frame, binary 1..64 |
| smp_par_fail | input | 1 | 1 when the sample's parity check failed |
| ci_valid | output | 1 | One-cycle strobe: new control bits are present |
| ci_bits | output | 2 | Bit 0 = first control bit, bit 1 = second control bit |

## Verification
Assertions check four properties on every cycle. No group count ever exceeds the group size. A count stays unchanged in cycles when it is neither cleared nor incremented. A count is zero after the start of a frame. The output strobe follows a final sample by exactly one cycle, and the bits hold between strobes. Only the bench scenarios can show that the vote threshold sits at three of five, that each group listens to the correct five positions, that early-frame failures and invalid cycles leave no trace, and that a restarted frame discards its partial counts. These properties depend on whole sample sequences, and the bench compares each result against a value it computes independently.

// File: rtl/ci_vote_pkg.sv
package ci_vote_pkg;

    // Frame geometry
    localparam int FRAME_LEN  = 64;
    localparam int GROUP_LEN  = 5;
    localparam int NUM_GROUPS = 2;

    // Derived constants
    localparam int IDX_W     = $clog2(FRAME_LEN + 1);
    localparam int CNT_W     = $clog2(GROUP_LEN + 1);
    localparam int FIRST_IDX = FRAME_LEN - NUM_GROUPS * GROUP_LEN + 1;
    localparam int MAJ_LIMIT = GROUP_LEN / 2 + 1;

    // Decoded view of one incoming sample
    typedef struct packed {
        logic                  start;  // first position of a frame
        logic                  last;   // final position of a frame
        logic                  fail;   // parity check failed
        logic [NUM_GROUPS-1:0] hit;    // sample belongs to group g
    } smp_dec_t;

    typedef logic [NUM_GROUPS-1:0][CNT_W-1:0] cnt_vec_t;

    function automatic logic majority(input logic [CNT_W-1:0] cnt);
        return int'(cnt) >= MAJ_LIMIT;
    endfunction

    function automatic int group_lo(input int g);
        return FIRST_IDX + g * GROUP_LEN;
    endfunction

endpackage

// File: rtl/ci_vote_decode.sv
module ci_vote_decode
    import ci_vote_pkg::*;
(
    input  logic             smp_valid,
    input  logic [IDX_W-1:0] smp_index,
    input  logic             smp_par_fail,
    output smp_dec_t         dec
);

    logic [NUM_GROUPS-1:0] in_group;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_win
        always_comb begin
            in_group[g] = (int'(smp_index) >= group_lo(g)) &&
                          (int'(smp_index) <  group_lo(g) + GROUP_LEN);
        end
    end

    always_comb begin
        dec = '0;
        if (smp_valid) begin
            dec.start = (int'(smp_index) == 1);
            dec.last  = (int'(smp_index) == FRAME_LEN);
            dec.fail  = smp_par_fail;
            dec.hit   = in_group;
        end
    end

endmodule

// File: rtl/ci_vote_counter.sv
module ci_vote_counter #(
    parameter int LIMIT = 5,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_next
);

    logic [W-1:0] cnt_q;

    always_comb cnt_next = cnt_q + W'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= cnt_next;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= LIMIT);                                   // R5
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);                                    // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(cnt_q));                      // R10

endmodule

// File: rtl/ci_vote_out.sv
module ci_vote_out
    import ci_vote_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  cnt_vec_t              cnt_next,
    output logic                  ci_valid,
    output logic [NUM_GROUPS-1:0] ci_bits
);

    logic [NUM_GROUPS-1:0] vote;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_vote
        always_comb vote[g] = majority(cnt_next[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ci_valid <= 1'b0;
            ci_bits  <= '0;
        end else begin
            ci_valid <= fire;
            if (fire) ci_bits <= vote;
        end
    end

    AST_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(ci_bits));                             // R8
    AST_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !ci_valid);                                    // R7
    AST_EVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fire && cnt_next[0] == '0) |=> !ci_bits[0]);            // R4

endmodule

// File: rtl/ci_parity_vote.sv
module ci_parity_vote
    import ci_vote_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_valid,
    input  logic [IDX_W-1:0]      smp_index,
    input  logic                  smp_par_fail,
    output logic                  ci_valid,
    output logic [NUM_GROUPS-1:0] ci_bits
);

    smp_dec_t dec;
    cnt_vec_t cnt_next;

    ci_vote_decode u_decode (
        .smp_valid    (smp_valid),
        .smp_index    (smp_index),
        .smp_par_fail (smp_par_fail),
        .dec          (dec)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cnt
        ci_vote_counter #(.LIMIT(GROUP_LEN), .W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .clr      (dec.start || dec.last),
            .inc      (dec.hit[g] && dec.fail),
            .cnt_next (cnt_next[g])
        );
    end

    ci_vote_out u_out (
        .clk      (clk),
        .rst      (rst),
        .fire     (dec.last),
        .cnt_next (cnt_next),
        .ci_valid (ci_valid),
        .ci_bits  (ci_bits)
    );

    AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && int'(smp_index) == FRAME_LEN) |=> ci_valid);   // R7
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !ci_valid);                                   // R10

endmodule

// File: tb/tb_ci_parity_vote.sv
module tb_ci_parity_vote;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [6:0] smp_index = '0;
    logic       smp_par_fail = 1'b0;
    logic       ci_valid;
    logic [1:0] ci_bits;

    int checks = 0;
    int failures = 0;
    logic [1:0] exp_q[$];
    logic [1:0] held_bits = 2'b00;
    logic       prev_valid = 1'b0;
    bit         monitor_on = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    ci_parity_vote dut (
        .clk          (clk),
        .rst          (rst),
        .smp_valid    (smp_valid),
        .smp_index    (smp_index),
        .smp_par_fail (smp_par_fail),
        .ci_valid     (ci_valid),
        .ci_bits      (ci_bits)
    );

    task automatic check(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: plays one frame of positions 1..last_idx and queues the expected result
    task automatic send_frame(input logic [64:1] f, input int last_idx, input bit gaps);
        int c1 = 0;
        int c2 = 0;
        for (int i = 55; i <= 59; i++) c1 += int'(f[i]);
        for (int i = 60; i <= 64; i++) c2 += int'(f[i]);
        if (last_idx == 64) exp_q.push_back({c2 >= 3, c1 >= 3});
        for (int i = 1; i <= last_idx; i++) begin
            if (gaps && (i % 7 == 0)) begin
                @(posedge clk); #1;
                smp_valid = 1'b0; smp_index = 7'd57; smp_par_fail = 1'b1;  // R10 bait
            end
            @(posedge clk); #1;
            smp_valid = 1'b1; smp_index = 7'(i); smp_par_fail = f[i];
        end
        @(posedge clk); #1;
        smp_valid = 1'b0; smp_par_fail = 1'b0;
    endtask

    // Monitor: pops expected results on each strobe
    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            if (ci_valid) begin
                check(!prev_valid, "R7 strobe width", {2'b0, prev_valid}, 3'b0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected strobe", {1'b0, ci_bits}, 3'b0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check(ci_bits == e, "R2/R3/R5 vote", {1'b0, ci_bits}, {1'b0, e});
                end
                held_bits = ci_bits;
            end else begin
                check(ci_bits == held_bits, "R8 hold", {1'b0, ci_bits}, {1'b0, held_bits});
            end
            prev_valid = ci_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [64:1] f;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ci_valid == 1'b0 && ci_bits == 2'b00, "R1 reset", {ci_valid, ci_bits}, 3'b000);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(ci_valid == 1'b0 && ci_bits == 2'b00, "R1 after reset", {ci_valid, ci_bits}, 3'b000);
        monitor_on = 1'b1;

        // R4: all parity checks pass
        f = '0;
        send_frame(f, 64, 1'b0);
        // R2 R5: first group 3 fails, second group 2
        f = '0; f[55] = 1; f[57] = 1; f[59] = 1; f[60] = 1; f[64] = 1;
        send_frame(f, 64, 1'b0);
        // R3 R5: first group 2 fails, second group 3
        f = '0; f[56] = 1; f[58] = 1; f[61] = 1; f[62] = 1; f[63] = 1;
        send_frame(f, 64, 1'b0);
        // R2 R3: every sample fails
        f = '1;
        send_frame(f, 64, 1'b0);
        // R6: failures only in positions 1..54
        f = '0; for (int i = 1; i <= 54; i++) f[i] = 1;
        send_frame(f, 64, 1'b0);
        // R10: idle cycles carry in-group fail flags that must be ignored
        f = '0; f[55] = 1; f[59] = 1; f[62] = 1; f[63] = 1; f[64] = 1;
        send_frame(f, 64, 1'b1);
        // R9: partial frame with 3 fails in first group, then restart
        f = '0; f[55] = 1; f[56] = 1; f[57] = 1;
        send_frame(f, 60, 1'b0);
        f = '0; f[58] = 1; f[59] = 1;
        send_frame(f, 64, 1'b0);
        // R5: four and five fails
        f = '0; f[55] = 1; f[56] = 1; f[58] = 1; f[59] = 1;
        for (int i = 60; i <= 64; i++) f[i] = 1;
        send_frame(f, 64, 1'b0);

        repeat (5) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R7 missing strobe", 3'(exp_q.size()), 3'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule